// File: doc/BRIEF.md
# Flash Address Range Protection Checker

This block sits beside a flash sequencer and decides, for every flash access request, whether the access may proceed. It holds a bank of guard-range registers and a bank of flash-region registers. Each guard range names a span of 4 KB pages and carries separate enables for read and write protection. When a request's address falls inside an active range whose enable matches the request's direction, the request is denied. The block then pulses an access-error line so the sequencer can report a protection fault rather than a generic cycle error.

Registers are loaded through a simple write port that selects a bank and an index. A sticky lock input freezes the guard ranges until reset. The region bank stays writable after lock. Each region word is decoded into an enabled or disabled flag that the rest of the chip can use. Requests are evaluated against the register contents present in the cycle the request is presented. The verdict appears one clock later.

Top module: `flash_guard`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_deny` and `acc_err` are low. Every guard word and region word is zero, so `region_en` is all zeros.
- R2: A request presented with `req_valid` high on a clock edge produces `rsp_valid` high for exactly the following cycle. With no request, `rsp_valid` and `rsp_deny` are low.
- R3: A guard word places the first page in bits 13:0 and the last page in bits 29:16, both in 4 KB units. The range covers byte addresses from first×4096 through last×4096 + 0xFFF, both ends inclusive.
- R4: Bit 31 of a guard word protects writes (`req_write`=1) only. Bit 15 protects reads (`req_write`=0) only.
- R5: A guard word with neither bit 31 nor bit 15 set never denies any access.
- R6: A request is denied if any protecting range covers it. Ranges are combined by OR, so different ranges may deny different directions at the same address.
- R7: `acc_err` is high in a cycle exactly when `rsp_valid` and `rsp_deny` are both high in that cycle.
- R8: A guard word whose first page is above its last page covers no address.
- R9: A region word uses the same field positions as a guard word. Region i is enabled when its first page is strictly below its last page and, for i other than 0, its last page is non-zero. `region_en` reflects a region write from the cycle after the write.
- R10: Once `lock_in` has been high on a clock edge, writes to the guard bank are ignored until reset. Region writes still take effect.
- R11: Writes select the bank with `cfg_region` (0 = guard ranges, 1 = flash regions) and the entry with `cfg_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_region | input | 1 | Bank select: 0 guard range, 1 flash region |
| cfg_idx | input | 4 | Entry index within the selected bank |
| cfg_wdata | input | 32 | Register write data |
| lock_in | input | 1 | Sets the sticky guard-bank lock |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W (24) | Byte address of the access |
| req_write | input | 1 | 1 for write or erase, 0 for read |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_deny | output | 1 | Verdict: access falls in a protecting range |
| acc_err | output | 1 | Access-error pulse toward the sequencer |
| region_en | output | NUM_REGIONS (5) | Per-region enabled flag |

## Verification
The assertions assume reset is applied before the first request. They also assume `req_valid` is a plain strobe with no back-pressure, so every request must produce a verdict on the next edge. The lock-hold property assumes the guard bank changes only through the write port. The bench therefore drives all inputs on the falling edge. It never writes a guard word in the same cycle that `lock_in` rises, and it releases the lock only with `rst`.

// File: rtl/fguard_pkg.sv
package fguard_pkg;

    localparam int FIELD_W    = 14;
    localparam int PAGE_SHIFT = 12;
    localparam int SEL_W      = 4;
    localparam int WORD_W     = 32;

    // One guard or region word; field positions are decoded by neighbours.
    typedef struct packed {
        logic               wr_prot;
        logic               rsv_hi;
        logic [FIELD_W-1:0] last_pg;
        logic               rd_prot;
        logic               rsv_lo;
        logic [FIELD_W-1:0] first_pg;
    } span_word_t;

    typedef enum logic {
        BANK_GUARD  = 1'b0,
        BANK_REGION = 1'b1
    } bank_e;

    function automatic logic span_covers(span_word_t w, logic [FIELD_W-1:0] pg);
        return (pg >= w.first_pg) && (pg <= w.last_pg);
    endfunction

    function automatic logic span_protects(span_word_t w, logic is_write);
        return is_write ? w.wr_prot : w.rd_prot;
    endfunction

    function automatic logic region_live(span_word_t w, logic is_first);
        return (w.first_pg < w.last_pg) && (is_first || (w.last_pg != '0));
    endfunction

endpackage

// File: rtl/fg_regbank.sv
module fg_regbank
    import fguard_pkg::*;
#(
    parameter int NUM_RANGES  = 5,
    parameter int NUM_REGIONS = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic                          cfg_region,
    input  logic [SEL_W-1:0]              cfg_idx,
    input  logic [WORD_W-1:0]             cfg_wdata,
    input  logic                          lock_in,
    output span_word_t [NUM_RANGES-1:0]   guard_q,
    output span_word_t [NUM_REGIONS-1:0]  region_q,
    output logic                          locked_q
);

    bank_e bank_sel;
    assign bank_sel = bank_e'(cfg_region);

    always_ff @(posedge clk) begin
        if (rst)          locked_q <= 1'b0;
        else if (lock_in) locked_q <= 1'b1;
    end

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_guard
        always_ff @(posedge clk) begin
            if (rst)
                guard_q[g] <= '0;
            else if (cfg_we && !locked_q && bank_sel == BANK_GUARD &&
                     cfg_idx == SEL_W'(g))
                guard_q[g] <= span_word_t'(cfg_wdata);
        end
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        always_ff @(posedge clk) begin
            if (rst)
                region_q[r] <= '0;
            else if (cfg_we && bank_sel == BANK_REGION && cfg_idx == SEL_W'(r))
                region_q[r] <= span_word_t'(cfg_wdata);
        end
    end

endmodule

// File: rtl/fg_range_match.sv
module fg_range_match
    import fguard_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int ADDR_W     = 24
) (
    input  span_word_t [NUM_RANGES-1:0] guard_q,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        is_write,
    output logic [NUM_RANGES-1:0]       hit_vec,
    output logic                        deny
);

    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

    logic [FIELD_W-1:0] page;
    assign page = FIELD_W'(addr[ADDR_W-1:PAGE_SHIFT]);

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_hit
        assign hit_vec[g] = span_covers(guard_q[g], page) &&
                            span_protects(guard_q[g], is_write);
    end

    assign deny = |hit_vec;

    logic unused_bits;
    assign unused_bits = ^{addr[PAGE_SHIFT-1:0], PAGE_W};

endmodule

// File: rtl/fg_region_decode.sv
module fg_region_decode
    import fguard_pkg::*;
#(
    parameter int NUM_REGIONS = 5
) (
    input  span_word_t [NUM_REGIONS-1:0] region_q,
    output logic [NUM_REGIONS-1:0]       region_en
);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_dec
        if (r == 0) begin : g_first
            assign region_en[r] = region_live(region_q[r], 1'b1);
        end else begin : g_rest
            assign region_en[r] = region_live(region_q[r], 1'b0);
        end
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import fguard_pkg::*;
#(
    parameter int NUM_RANGES  = 5,
    parameter int NUM_REGIONS = 5,
    parameter int ADDR_W      = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic                   cfg_region,
    input  logic [3:0]             cfg_idx,
    input  logic [31:0]            cfg_wdata,
    input  logic                   lock_in,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_write,
    output logic                   rsp_valid,
    output logic                   rsp_deny,
    output logic                   acc_err,
    output logic [NUM_REGIONS-1:0] region_en
);

    span_word_t [NUM_RANGES-1:0]  guard_words;
    span_word_t [NUM_REGIONS-1:0] region_words;
    logic                         lock_q;
    logic [NUM_RANGES-1:0]        hit_vec;
    logic                         deny_now;

    fg_regbank #(.NUM_RANGES(NUM_RANGES), .NUM_REGIONS(NUM_REGIONS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_region(cfg_region),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .lock_in   (lock_in),
        .guard_q   (guard_words),
        .region_q  (region_words),
        .locked_q  (lock_q)
    );

    fg_range_match #(.NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W)) u_match (
        .guard_q (guard_words),
        .addr    (req_addr),
        .is_write(req_write),
        .hit_vec (hit_vec),
        .deny    (deny_now)
    );

    fg_region_decode #(.NUM_REGIONS(NUM_REGIONS)) u_regdec (
        .region_q (region_words),
        .region_en(region_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_deny  <= 1'b0;
            acc_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_deny  <= req_valid && deny_now;
            acc_err   <= req_valid && (hit_vec != '0);
        end
    end

endmodule

// File: rtl/fg_guard_checker.sv
module fg_guard_checker #(
    parameter int NUM_RANGES = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     rsp_valid,
    input logic                     rsp_deny,
    input logic                     acc_err,
    input logic                     locked,
    input logic [32*NUM_RANGES-1:0] guard_flat
);

    logic none_active;
    always_comb begin
        none_active = 1'b1;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (guard_flat[32*i+31] || guard_flat[32*i+15]) none_active = 1'b0;
        end
    end

    p_verdict_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_deny));
    p_err_match_r7: assert property (@(posedge clk) disable iff (rst)
        acc_err == (rsp_valid && rsp_deny));
    p_inactive_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && none_active) |=> !rsp_deny);
    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);
    p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(guard_flat));

endmodule

bind flash_guard fg_guard_checker #(.NUM_RANGES(NUM_RANGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_deny  (rsp_deny),
    .acc_err   (acc_err),
    .locked    (lock_q),
    .guard_flat(guard_words)
);

// File: tb/tb_flash_guard.sv
module tb_flash_guard;

    localparam int NR = 5;
    localparam int NG = 5;
    localparam int AW = 24;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we, cfg_region, lock_in, req_valid, req_write;
    logic [3:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic [AW-1:0] req_addr;
    logic rsp_valid, rsp_deny, acc_err;
    logic [NG-1:0] region_en;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    flash_guard #(.NUM_RANGES(NR), .NUM_REGIONS(NG), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_region(cfg_region),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .lock_in(lock_in),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_deny(rsp_deny), .acc_err(acc_err),
        .region_en(region_en)
    );

    // {write, address, expected deny}
    localparam int NV = 17;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 24'h00FFFF, 1'b0},  // R3 below first page
        {1'b1, 24'h010000, 1'b1},  // R3 first byte
        {1'b1, 24'h011FFF, 1'b1},  // R3 last byte inclusive
        {1'b1, 24'h012000, 1'b0},  // R3 one past end
        {1'b0, 24'h010800, 1'b0},  // R4 write-only range lets reads pass
        {1'b0, 24'h020000, 1'b1},  // R4 read protect
        {1'b0, 24'h020FFF, 1'b1},  // R3 single page upper byte
        {1'b0, 24'h021000, 1'b0},  // R3 past single page
        {1'b1, 24'h020500, 1'b0},  // R4 read-only range lets writes pass
        {1'b0, 24'h030000, 1'b0},  // R5 inactive
        {1'b1, 24'h031FFF, 1'b0},  // R5 inactive
        {1'b0, 24'h040000, 1'b0},  // R8 inverted range
        {1'b1, 24'h03F000, 1'b0},  // R8 inverted range
        {1'b0, 24'h050000, 1'b1},  // R4 both enables
        {1'b1, 24'h052FFF, 1'b1},  // R4 both enables
        {1'b1, 24'h053000, 1'b0},  // R3 end
        {1'b0, 24'h04FFFF, 1'b0}   // R3 start
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic bank, logic [3:0] idx, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = bank; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(string tag, logic wr, logic [AW-1:0] a, logic exp_deny);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " rsp_valid (R2)"}, 32'(rsp_valid), 32'd1);
        chk({tag, " deny"}, 32'(rsp_deny), 32'(exp_deny));
        chk({tag, " acc_err (R7)"}, 32'(acc_err), 32'(exp_deny));
        @(negedge clk);
        chk({tag, " idle after (R2)"}, 32'({rsp_valid, acc_err}), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_region = 0; cfg_idx = 0; cfg_wdata = 0;
        lock_in = 0; req_valid = 0; req_write = 0; req_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 reset deny/err", 32'({rsp_deny, acc_err}), 32'd0);
        chk("R1 reset region_en", 32'(region_en), 32'd0);
        access("R1 empty guard bank", 1'b1, 24'h010000, 1'b0);

        // Guard bank (R11 bank 0)
        wr_reg(1'b0, 4'd0, 32'h8011_0010);   // write protect pages 0x010-0x011
        wr_reg(1'b0, 4'd1, 32'h0020_8020);   // read protect page 0x020
        wr_reg(1'b0, 4'd2, 32'h0031_0030);   // no enables
        wr_reg(1'b0, 4'd3, 32'h803F_8040);   // first above last
        wr_reg(1'b0, 4'd4, 32'h8052_8050);   // both, pages 0x050-0x052

        for (int i = 0; i < NV; i++) begin
            access($sformatf("vec%0d R3/R4/R5/R8", i), VEC[i][25], VEC[i][24:1], VEC[i][0]);
        end

        // R6 overlap: range 2 read-protects page 0x011 under range 0's write span
        wr_reg(1'b0, 4'd2, 32'h0011_8011);
        access("R6 read hit second range", 1'b0, 24'h011800, 1'b1);
        access("R6 write hit first range", 1'b1, 24'h011800, 1'b1);
        access("R6 read outside second", 1'b0, 24'h010800, 1'b0);

        // R9 region decode (R11 bank 1)
        wr_reg(1'b1, 4'd0, 32'h00FF_0000);   // enabled
        wr_reg(1'b1, 4'd1, 32'h0000_0100);   // last zero: disabled
        wr_reg(1'b1, 4'd2, 32'h0000_0000);   // disabled
        wr_reg(1'b1, 4'd3, 32'h0005_0005);   // equal: disabled
        wr_reg(1'b1, 4'd4, 32'h0020_0010);   // enabled
        chk("R9 region_en pattern", 32'(region_en), 32'h11);
        wr_reg(1'b1, 4'd0, 32'h0000_0000);
        chk("R9 region0 first equals last", 32'(region_en), 32'h10);

        // R10 lock
        @(negedge clk); lock_in = 1'b1;
        @(negedge clk); lock_in = 1'b0;
        wr_reg(1'b0, 4'd0, 32'h0000_0000);   // must be ignored
        access("R10 guard unchanged after lock", 1'b1, 24'h010000, 1'b1);
        wr_reg(1'b1, 4'd2, 32'h0040_0030);
        chk("R10 region writable after lock", 32'(region_en), 32'h14);

        // Reset releases lock and clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 region_en after reset", 32'(region_en), 32'd0);
        access("R1 guard cleared by reset", 1'b1, 24'h010000, 1'b0);
        wr_reg(1'b0, 4'd0, 32'h8000_0000);   // write protect page 0 only
        access("R10 writable after reset", 1'b1, 24'h000FFF, 1'b1);
        access("R4 read passes page 0", 1'b0, 24'h000000, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule